// File: doc/BRIEF.md
# AUX Channel Transaction Controller

This block is the register-side half of a DisplayPort AUX-channel master. Software sees a small word-addressed register file. It loads a target address, a command with a byte count, and up to sixteen bytes of write data. It then launches the transfer by setting a go bit. The block presents the request to a line-side serializer through a held request bundle. It waits for the serializer's reply or for a programmable cycle budget to run out, whichever comes first. It then latches the reply type, the received byte count, the error flags and the read data into registers.

Native reads and writes are supported, as are I2C-over-AUX reads, writes and write-status-update requests. Each I2C request has a variant that keeps the I2C transaction open. I2C requests may also be sent address-only, with no data phase. Separately, a synchronised and debounced hot-plug-detect input raises plug and unplug events. A one-cycle sink-interrupt pulse from the line side raises its own event. These events and transaction completion feed a maskable interrupt output.

Register word map (reg_addr):
- 0 = target address.
- 1 = control:
  - bits 3:0 hold byte count minus one.
  - bit 8 is the address-only flag.
  - bits 15:12 hold the command.
  - bit 16 is the go bit, which reads back as busy.
- 2 = status:
  - bits 4:0 hold the received byte count.
  - bits 11:8 hold the error flags.
  - bits 19:16 hold the reply type.
  - bit 28 is the debounced hot-plug level.
- 3 = interrupt enable.
- 4 = interrupt pending.
- 5 = configuration: bits 15:0 hold the timeout budget and bits 31:16 hold the debounce length.
- 8 to 11 = transmit words.
- 12 to 15 = receive words.

Top module: `aux_xact_ctrl`

## Requirements
- R1: After reset, every register reads zero except configuration, which reads 0x0003_0064. req_valid and irq are low.
- R2: A control write with bit 16 set, made while idle, sets req_valid from the next cycle, provided the command is supported. The supported commands are 0 I2C write, 1 I2C read, 2 I2C write-status-update, 4/5/6 the same three with the transaction kept open, 8 native write and 9 native read. Any other command value starts nothing.
- R3: While a request is presented, req_cmd and req_addr equal the loaded command and address. req_len equals the control length field plus one, in the range 1 to 16.
- R4: The address-only flag makes req_len zero when the command is an I2C one (bit 3 clear). The flag has no effect on native commands.
- R5: Transmit byte n appears at req_data[8n+7:8n], taken from word n/4 at lane n%4. Bytes at positions req_len and above are driven as zero.
- R6: While busy, writes to the address, control and transmit registers are ignored.
- R7: A cycle with rsp_valid while busy ends the transaction: req_valid and the go bit clear on the next cycle, and pending bit 0 (done) sets. Reply type and byte count are latched into status. rsp_valid while idle changes nothing.
- R8: Receive byte n is stored little-endian in the receive words. Bytes at positions rsp_count and above are stored as zero.
- R9: rsp_err bits 0/1/2 (receive error, sink-status error, missing stop) set status bits 9/10/11. Status bits 11:8 clear only when a 1 is written to them.
- R10: If no reply has arrived within the timeout budget of cycles after the start, the transaction ends with status bit 8 set, a received count of zero, and done pending.
- R11: Pending bits are 0 done, 1 sink interrupt, 2 unplug, 3 plug. Writing 1 to a pending bit clears it. irq is high when any pending bit is also enabled.
- R12: hot_plug passes through a two-stage synchroniser. A new level is accepted only after it has differed from the current one for debounce-length+1 consecutive cycles. A rise sets plug pending, a fall sets unplug pending, and status bit 28 shows the accepted level. Shorter glitches raise nothing.
- R13: A sink_irq pulse sets pending bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| req_valid | output | 1 | Request in flight |
| req_cmd | output | 4 | Request command code |
| req_addr | output | 20 | Request target address |
| req_len | output | 5 | Request byte count (0 = address-only) |
| req_data | output | 128 | Request write bytes |
| rsp_valid | input | 1 | Reply strobe |
| rsp_type | input | 4 | Reply type, one-hot style code |
| rsp_count | input | 5 | Reply byte count |
| rsp_err | input | 3 | Reply error flags |
| rsp_data | input | 128 | Reply read bytes |
| sink_irq | input | 1 | Sink interrupt event pulse |
| hot_plug | input | 1 | Asynchronous hot-plug-detect level |

## Verification
A busy flag stuck high shows up as req_valid failing to drop one cycle after a reply. A flag that never set shows up as req_valid missing one cycle after a go write. A reference model compares req_valid and irq on every clock, so either fault is reported within a cycle. A wrong timeout counter or debounce counter moves the done or plug event by at least one cycle, which the per-clock irq comparison exposes. Wrong lane masking or latching errors surface at the next read of a data or status word, or directly on req_len and req_data.

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl #(
  parameter int AW     = 20,
  parameter int TO_RST = 100,
  parameter int DB_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              req_valid,
  output logic [3:0]        req_cmd,
  output logic [AW-1:0]     req_addr,
  output logic [4:0]        req_len,
  output logic [127:0]      req_data,
  input  logic              rsp_valid,
  input  logic [3:0]        rsp_type,
  input  logic [4:0]        rsp_count,
  input  logic [2:0]        rsp_err,
  input  logic [127:0]      rsp_data,
  input  logic              sink_irq,
  input  logic              hot_plug
);
  localparam int WORDS = 4;
  localparam int NB    = WORDS * 4;
  localparam int CW    = $clog2(NB + 1);
  localparam int LW    = $clog2(NB);

  logic [AW-1:0]   addr_q;
  logic [LW-1:0]   len_q;
  logic            aonly_q;
  logic [3:0]      cmd_q;
  logic            busy;
  logic [NB*8-1:0] tx_q, rx_q, rx_next;
  logic [CW-1:0]   cnt_q;
  logic [3:0]      err_q, type_q;
  logic [3:0]      int_en, int_pend;
  logic [15:0]     to_lim, to_cnt, db_lim, db_cnt;
  logic [1:0]      hsync;
  logic            hpd_lvl;

  function automatic logic cmd_ok(input logic [3:0] c);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9: cmd_ok = 1'b1;
      default: cmd_ok = 1'b0;
    endcase
  endfunction

  wire wr_ctrl = reg_we && reg_addr == 4'd1;
  wire start   = !busy && wr_ctrl && reg_wdata[16] && cmd_ok(reg_wdata[15:12]);
  wire fin_ok  = busy && rsp_valid;
  wire fin_to  = busy && !rsp_valid && to_cnt == to_lim;
  wire hpd_chg = hsync[1] != hpd_lvl && db_cnt == db_lim;
  wire [3:0] ev = {hpd_chg && hsync[1], hpd_chg && !hsync[1], sink_irq, fin_ok || fin_to};
  wire [3:0] pend_clr = (reg_we && reg_addr == 4'd4) ? reg_wdata[3:0] : 4'd0;
  wire [3:0] err_clr  = (reg_we && reg_addr == 4'd2) ? reg_wdata[11:8] : 4'd0;
  wire [3:0] err_set  = fin_to ? 4'b0001 : fin_ok ? {rsp_err, 1'b0} : 4'b0000;

  assign req_valid = busy;
  assign req_cmd   = cmd_q;
  assign req_addr  = addr_q;
  assign req_len   = (aonly_q && !cmd_q[3]) ? '0 : CW'(len_q) + CW'(1);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign req_data[8*b +: 8] = (CW'(b) < req_len)   ? tx_q[8*b +: 8]     : 8'h00;
    assign rx_next[8*b +: 8]  = (CW'(b) < rsp_count) ? rsp_data[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; len_q <= '0; aonly_q <= 1'b0; cmd_q <= '0; busy <= 1'b0;
      tx_q <= '0; rx_q <= '0; cnt_q <= '0; err_q <= '0; type_q <= '0;
      int_en <= '0; int_pend <= '0; to_cnt <= '0;
      to_lim <= 16'(TO_RST); db_lim <= 16'(DB_RST);
      db_cnt <= '0; hsync <= '0; hpd_lvl <= 1'b0;
    end else begin
      if (!busy) begin
        if (reg_we && reg_addr == 4'd0) addr_q <= reg_wdata[AW-1:0];
        if (wr_ctrl) begin
          len_q   <= reg_wdata[LW-1:0];
          aonly_q <= reg_wdata[8];
          cmd_q   <= reg_wdata[15:12];
        end
        if (reg_we && reg_addr[3:2] == 2'b10) tx_q[32*reg_addr[1:0] +: 32] <= reg_wdata;
      end
      if (start) begin
        busy   <= 1'b1;
        to_cnt <= '0;
      end else if (fin_ok || fin_to) begin
        busy <= 1'b0;
      end else if (busy) begin
        to_cnt <= to_cnt + 16'd1;
      end
      if (fin_ok) begin
        type_q <= rsp_type;
        cnt_q  <= rsp_count;
        rx_q   <= rx_next;
      end else if (fin_to) begin
        cnt_q <= '0;
      end
      err_q    <= (err_q & ~err_clr) | err_set;
      int_pend <= (int_pend & ~pend_clr) | ev;
      if (reg_we && reg_addr == 4'd3) int_en <= reg_wdata[3:0];
      if (reg_we && reg_addr == 4'd5) begin
        to_lim <= reg_wdata[15:0];
        db_lim <= reg_wdata[31:16];
      end
      hsync <= {hsync[0], hot_plug};
      if (hsync[1] != hpd_lvl) begin
        if (db_cnt == db_lim) begin
          hpd_lvl <= hsync[1];
          db_cnt  <= '0;
        end else begin
          db_cnt <= db_cnt + 16'd1;
        end
      end else begin
        db_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(((int_pend & ~pend_clr) | ev) & ((reg_we && reg_addr == 4'd3) ? reg_wdata[3:0] : int_en));
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0: reg_rdata = 32'(addr_q);
      4'd1: reg_rdata = {15'd0, busy, cmd_q, 3'd0, aonly_q, 4'd0, len_q};
      4'd2: reg_rdata = {3'd0, hpd_lvl, 8'd0, type_q, 4'd0, err_q, 3'd0, cnt_q};
      4'd3: reg_rdata = {28'd0, int_en};
      4'd4: reg_rdata = {28'd0, int_pend};
      4'd5: reg_rdata = {db_lim, to_lim};
      4'd8, 4'd9, 4'd10, 4'd11:  reg_rdata = tx_q[32*reg_addr[1:0] +: 32];
      4'd12, 4'd13, 4'd14, 4'd15: reg_rdata = rx_q[32*reg_addr[1:0] +: 32];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/aux_xact_chk.sv
module aux_xact_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          irq,
  input logic          req_valid,
  input logic [3:0]    req_cmd,
  input logic [AW-1:0] req_addr,
  input logic [4:0]    req_len,
  input logic          rsp_valid,
  input logic          sink_irq,
  input logic [3:0]    pend
);
  a_r2_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !(reg_we && reg_addr == 4'd1 && reg_wdata[16])) |=> !req_valid);

  a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_len <= 5'd16);

  a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid) |=>
      (!req_valid || ($stable(req_cmd) && $stable(req_addr) && $stable(req_len))));

  a_r7_reply_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid) |=> !req_valid);

  a_r7_done_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid) |=> pend[0]);

  a_r13_sink_pending: assert property (@(posedge clk) disable iff (!rst_n)
    sink_irq |=> pend[1]);

  a_r11_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend != 4'd0);
endmodule

bind aux_xact_ctrl aux_xact_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_addr(req_addr), .req_len(req_len), .rsp_valid(rsp_valid),
  .sink_irq(sink_irq), .pend(int_pend)
);

// File: tb/aux_xact_ctrl_tb.sv
`timescale 1ns/1ps
module aux_xact_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, req_valid;
  logic [3:0] req_cmd;
  logic [19:0] req_addr;
  logic [4:0] req_len;
  logic [127:0] req_data;
  logic rsp_valid = 0;
  logic [3:0] rsp_type = 0;
  logic [4:0] rsp_count = 0;
  logic [2:0] rsp_err = 0;
  logic [127:0] rsp_data = 0;
  logic sink_irq = 0, hot_plug = 0;

  always #2.5 clk = ~clk;

  aux_xact_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_len(req_len), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_type(rsp_type), .rsp_count(rsp_count), .rsp_err(rsp_err),
    .rsp_data(rsp_data), .sink_irq(sink_irq), .hot_plug(hot_plug)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int m_busy, m_tcnt, m_to, m_db, m_dcnt, m_lvl, s0, s1, d;
  bit [3:0] m_pend, m_en, ev;

  function automatic bit okcmd(input logic [3:0] c);
    return c inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_tcnt = 0; m_to = 100; m_db = 3; m_dcnt = 0; m_lvl = 0;
      s0 = 0; s1 = 0; m_pend = 0; m_en = 0;
    end else begin
      ev = 0;
      d = s1;
      if (d != m_lvl) begin
        if (m_dcnt == m_db) begin m_lvl = d; ev[d ? 3 : 2] = 1; m_dcnt = 0; end
        else m_dcnt++;
      end else m_dcnt = 0;
      s1 = s0; s0 = int'(hot_plug);
      if (sink_irq) ev[1] = 1;
      if (m_busy != 0) begin
        if (rsp_valid || m_tcnt == m_to) begin m_busy = 0; ev[0] = 1; end
        else m_tcnt++;
      end else if (reg_we && reg_addr == 1 && reg_wdata[16] && okcmd(reg_wdata[15:12])) begin
        m_busy = 1; m_tcnt = 0;
      end
      if (reg_we && reg_addr == 4) m_pend &= ~reg_wdata[3:0];
      m_pend |= ev;
      if (reg_we && reg_addr == 3) m_en = reg_wdata[3:0];
      if (reg_we && reg_addr == 5) begin m_to = int'(reg_wdata[15:0]); m_db = int'(reg_wdata[31:16]); end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2/R7 req_valid vs model", {127'd0, req_valid}, {127'd0, m_busy != 0});
    chk("R11 irq vs model", {127'd0, irq}, {127'd0, |(m_pend & m_en)});
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic reply(input logic [3:0] t, input logic [4:0] c, input logic [2:0] e, input logic [127:0] dat);
    @(negedge clk); rsp_valid = 1; rsp_type = t; rsp_count = c; rsp_err = e; rsp_data = dat;
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'd1, v); chk("R1 control", v, 0);
    rd(4'd2, v); chk("R1 status", v, 0);
    rd(4'd4, v); chk("R1 pending", v, 0);
    rd(4'd5, v); chk("R1 config", v, 32'h0003_0064);
    chk("R1 req_valid", req_valid, 0);

    // R2 R3 R5 native write of three bytes
    wr(4'd0, 32'h12345);
    wr(4'd8, 32'hDDCCBBAA);
    wr(4'd9, 32'h11223344);
    wr(4'd1, 32'h0001_8002);
    chk("R2 started", req_valid, 1);
    chk("R3 cmd", req_cmd, 4'd8);
    chk("R3 len", req_len, 5'd3);
    chk("R3 addr", req_addr, 20'h12345);
    chk("R5 masked data", req_data, 128'h00CCBBAA);
    rd(4'd1, v); chk("R7 go reads busy", v, 32'h0001_8002);
    // R6 writes ignored while busy
    wr(4'd0, 32'h55555);
    wr(4'd1, 32'h0001_9005);
    wr(4'd8, 32'hFFFFFFFF);
    chk("R6 addr held", req_addr, 20'h12345);
    chk("R6 cmd held", req_cmd, 4'd8);
    chk("R6 len held", req_len, 5'd3);
    chk("R6 data held", req_data, 128'h00CCBBAA);
    reply(4'h0, 5'd0, 3'd0, '0);
    chk("R7 valid dropped", req_valid, 0);
    rd(4'd1, v); chk("R7 go cleared", v, 32'h0000_8002);
    rd(4'd4, v); chk("R7 done pending", v, 32'h1);
    rd(4'd2, v); chk("R7 status ack", v, 0);
    wr(4'd4, 32'hF);
    rd(4'd4, v); chk("R11 w1c pending", v, 0);

    // R3 R8 I2C read of sixteen bytes
    wr(4'd1, 32'h0001_100F);
    chk("R3 full len", req_len, 5'd16);
    chk("R3 read cmd", req_cmd, 4'd1);
    reply(4'h0, 5'd16, 3'd0, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111});
    rd(4'd12, v); chk("R8 rx word0", v, 32'h11111111);
    rd(4'd15, v); chk("R8 rx word3", v, 32'h44444444);
    rd(4'd2, v); chk("R7 count16", v, 32'h10);

    // R8 short reply on an open I2C read
    wr(4'd1, 32'h0001_5005);
    reply(4'h0, 5'd5, 3'd0, {128{1'b1}} & {16{8'hA5}});
    rd(4'd12, v); chk("R8 full word", v, 32'hA5A5A5A5);
    rd(4'd13, v); chk("R8 partial word", v, 32'h000000A5);
    rd(4'd14, v); chk("R8 zero word", v, 0);
    rd(4'd2, v); chk("R7 count5", v, 32'h5);

    // R4 R9 address-only I2C write, I2C NACK, receive error
    wr(4'd1, 32'h0001_0107);
    chk("R4 addr-only len", req_len, 5'd0);
    reply(4'h4, 5'd0, 3'b001, '0);
    rd(4'd2, v); chk("R9 rx err and type", v, 32'h0004_0200);
    wr(4'd2, 32'h0000_0F00);
    rd(4'd2, v); chk("R9 w1c all", v, 32'h0004_0000);

    // R4 flag ignored on native read; R9 partial clear
    wr(4'd1, 32'h0001_9103);
    chk("R4 native keeps len", req_len, 5'd4);
    chk("R4 native cmd", req_cmd, 4'd9);
    reply(4'h2, 5'd0, 3'b110, '0);
    rd(4'd2, v); chk("R9 sink and nostop", v, 32'h0002_0C00);
    wr(4'd2, 32'h0000_0400);
    rd(4'd2, v); chk("R9 single clear", v, 32'h0002_0800);
    wr(4'd2, 32'h0000_0F00);

    // R2 unsupported command starts nothing
    wr(4'd1, 32'h0001_3000);
    chk("R2 bad cmd idle", req_valid, 0);
    wr(4'd4, 32'hF);

    // R10 timeout with done interrupt enabled
    wr(4'd3, 32'h1);
    wr(4'd5, 32'h0003_000A);
    wr(4'd1, 32'h0001_8000);
    repeat (5) @(negedge clk);
    chk("R10 still waiting", req_valid, 1);
    repeat (15) @(negedge clk);
    chk("R10 ended", req_valid, 0);
    rd(4'd2, v); chk("R10 timeout flag", v, 32'h0002_0100);
    chk("R11 irq on done", irq, 1);
    // R7 reply while idle ignored
    reply(4'h8, 5'd3, 3'b111, '1);
    rd(4'd2, v); chk("R7 idle reply ignored", v, 32'h0002_0100);
    wr(4'd4, 32'h1);
    chk("R11 irq cleared", irq, 0);

    // R13 sink interrupt pulse
    wr(4'd3, 32'hF);
    @(negedge clk); sink_irq = 1;
    @(negedge clk); sink_irq = 0;
    rd(4'd4, v); chk("R13 sink pending", v, 32'h2);
    chk("R11 irq sink", irq, 1);
    wr(4'd4, 32'hF);

    // R12 hot-plug debounce
    @(negedge clk); hot_plug = 1;
    repeat (10) @(negedge clk);
    rd(4'd4, v); chk("R12 plug pending", v, 32'h8);
    rd(4'd2, v); chk("R12 level high", v[28], 1);
    wr(4'd4, 32'hF);
    @(negedge clk); hot_plug = 0;
    repeat (2) @(negedge clk); hot_plug = 1;
    repeat (10) @(negedge clk);
    rd(4'd4, v); chk("R12 glitch ignored", v, 0);
    rd(4'd2, v); chk("R12 level kept", v[28], 1);
    hot_plug = 0;
    repeat (10) @(negedge clk);
    rd(4'd4, v); chk("R12 unplug pending", v, 32'h4);
    rd(4'd2, v); chk("R12 level low", v[28], 0);

    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule